// File: doc/BRIEF.md
# Nibble ALU with Status Logic

This block is the combinational arithmetic and compare stage of a small 4-bit controller. Each cycle it takes an operation select, the accumulator, the memory nibble addressed by the data pointer, the Y register, a 4-bit immediate and a 2-bit bit index. From these it returns three things: the next accumulator value, the next Y value, and a write enable for each. It also returns the next status flag ST, which the surrounding core uses to decide conditional branches and calls.

Every arithmetic and compare form, including the negate, goes through one shared carry chain. What changes from form to form is the operand pair and the carry-in. The carry out of the chain is read as carry, as no-borrow or as "less or equal", depending on the operation. Equality and bit tests use a separate small unit. Moves and the no-op let values through and force ST to 1. Register storage, the memory write path and instruction decoding belong to the surrounding core.

Top module: `nib_alu`

## Requirements
- R1: Select codes are the `nib_alu_pkg::op_e` constants (0 to 23). For the memory-plus-accumulator add (OP_ADD_MA), the block writes (A+M) mod 16 to A and sets ST exactly when the 5-bit sum A+M exceeds 15.
- R2: The subtract (OP_SUB_MA) writes (M−A) mod 16 to A and sets ST exactly when A ≤ M.
- R3: The memory increment (OP_INC_M) writes (M+1) mod 16 to A with ST = 1 only for M = 15. The memory decrement (OP_DEC_M) writes (M−1) mod 16 to A with ST = 1 only for M ≥ 1.
- R4: The accumulator increment (OP_INC_A) writes (A+1) mod 16 to A with ST = 1 always. The accumulator decrement (OP_DEC_A) writes (A−1) mod 16 to A with ST = 1 only for A ≥ 1.
- R5: The Y increment (OP_INC_Y) writes (Y+1) mod 16 to Y with ST = 1 only for Y = 15. The Y decrement (OP_DEC_Y) writes (Y−1) mod 16 to Y with ST = 1 only for Y ≥ 1. Neither writes A.
- R6: The negate (OP_NEG_A) writes (16−A) mod 16 to A and sets ST only when A = 0.
- R7: The exclusive-or (OP_XOR_MA) writes A XOR M to A and sets ST.
- R8: The compares OP_LE_AM (A ≤ M) and OP_LE_AI (A ≤ immediate) set ST exactly when the relation holds. They write neither A nor Y.
- R9: OP_NZ_M (M ≠ 0), OP_NE_YA (Y ≠ A) and OP_NE_YI (Y ≠ immediate) set ST only on inequality. They write neither register.
- R10: The bit test (OP_TEST_BIT) sets ST to bit n of M, where n is the bit index (bit 0 is the least significant). It writes neither register.
- R11: The moves set ST to 1: OP_A_FROM_Y, OP_Y_FROM_A, OP_A_CLR (A=0), OP_A_FROM_M, OP_Y_FROM_M and OP_Y_FROM_I. Each writes only its destination. OP_NOP and the unused codes 24 to 31 set ST to 1 and write nothing.
- R12: Whenever a write enable is low, the matching value output equals its input unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation select (op_e code) |
| a_i | input | 4 | Current accumulator |
| m_i | input | 4 | Addressed memory nibble |
| y_i | input | 4 | Current Y register |
| imm_i | input | 4 | Instruction immediate |
| bit_i | input | 2 | Bit index for the bit test |
| a_o | output | 4 | Next accumulator value |
| y_o | output | 4 | Next Y value |
| a_we_o | output | 1 | Accumulator write enable |
| y_we_o | output | 1 | Y write enable |
| st_o | output | 1 | Next status flag |

## Verification
The checker assumes that all inputs are known 2-state values that stay steady while it evaluates. It also assumes that the bit index never goes past the nibble width, which holds by construction for a 2-bit index at width 4. The stimulus changes inputs only on one clock phase and samples on the other. It covers every defined select code and one unused code. It sweeps every accumulator value against every memory or immediate value for the add, the subtract and the immediate compare, so the carry conventions are exercised at both of their boundaries.

// File: rtl/nib_alu_pkg.sv
`timescale 1ns/1ps
package nib_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 5'd0,
    OP_ADD_MA   = 5'd1,
    OP_SUB_MA   = 5'd2,
    OP_INC_M    = 5'd3,
    OP_DEC_M    = 5'd4,
    OP_INC_A    = 5'd5,
    OP_DEC_A    = 5'd6,
    OP_INC_Y    = 5'd7,
    OP_DEC_Y    = 5'd8,
    OP_NEG_A    = 5'd9,
    OP_XOR_MA   = 5'd10,
    OP_LE_AM    = 5'd11,
    OP_LE_AI    = 5'd12,
    OP_NZ_M     = 5'd13,
    OP_NE_YA    = 5'd14,
    OP_NE_YI    = 5'd15,
    OP_TEST_BIT = 5'd16,
    OP_A_FROM_Y = 5'd17,
    OP_Y_FROM_A = 5'd18,
    OP_A_CLR    = 5'd19,
    OP_A_FROM_M = 5'd20,
    OP_Y_FROM_M = 5'd21,
    OP_Y_FROM_I = 5'd22,
    OP_RSVD23   = 5'd23
  } op_e;
endpackage

// File: rtl/nib_ripple.sv
`timescale 1ns/1ps
module nib_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign sum_o[b] = x_i[b] ^ y_i[b] ^ c[b];
    assign c[b+1]   = (x_i[b] & y_i[b]) | (c[b] & (x_i[b] ^ y_i[b]));
  end

  assign cout_o = c[W];
endmodule

// File: rtl/nib_opsel.sv
`timescale 1ns/1ps
module nib_opsel
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] z_o,
  output logic         cin_o
);
  // subtract-like forms add the inverted operand with carry-in 1;
  // decrements add all-ones so carry out means no borrow
  always_comb begin
    x_o   = '0;
    z_o   = '0;
    cin_o = 1'b0;
    unique case (op_i)
      OP_ADD_MA: begin x_o = m_i;   z_o = a_i;                end
      OP_SUB_MA: begin x_o = m_i;   z_o = ~a_i; cin_o = 1'b1; end
      OP_INC_M:  begin x_o = m_i;               cin_o = 1'b1; end
      OP_DEC_M:  begin x_o = m_i;   z_o = '1;                 end
      OP_INC_A:  begin x_o = a_i;               cin_o = 1'b1; end
      OP_DEC_A:  begin x_o = a_i;   z_o = '1;                 end
      OP_INC_Y:  begin x_o = y_i;               cin_o = 1'b1; end
      OP_DEC_Y:  begin x_o = y_i;   z_o = '1;                 end
      OP_NEG_A:  begin              z_o = ~a_i; cin_o = 1'b1; end
      OP_LE_AM:  begin x_o = m_i;   z_o = ~a_i; cin_o = 1'b1; end
      OP_LE_AI:  begin x_o = imm_i; z_o = ~a_i; cin_o = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/nib_test.sv
`timescale 1ns/1ps
module nib_test #(
  parameter int W     = 4,
  parameter int BIT_W = $clog2(W)
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     m_i,
  input  logic [W-1:0]     y_i,
  input  logic [W-1:0]     imm_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic             ya_ne_o,
  output logic             yi_ne_o,
  output logic             m_nz_o,
  output logic             m_bit_o
);
  logic [W-1:0] d_ya, d_yi;

  for (genvar b = 0; b < W; b++) begin : g_diff
    assign d_ya[b] = y_i[b] ^ a_i[b];
    assign d_yi[b] = y_i[b] ^ imm_i[b];
  end

  assign ya_ne_o = |d_ya;
  assign yi_ne_o = |d_yi;
  assign m_nz_o  = |m_i;
  assign m_bit_o = m_i[bit_i];
endmodule

// File: rtl/nib_alu.sv
`timescale 1ns/1ps
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W     = 4,
  parameter int BIT_W = $clog2(W)
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     m_i,
  input  logic [W-1:0]     y_i,
  input  logic [W-1:0]     imm_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     y_o,
  output logic             a_we_o,
  output logic             y_we_o,
  output logic             st_o
);
  op_e          op;
  logic [W-1:0] add_x, add_z, add_sum;
  logic         add_cin, add_cout;
  logic         ya_ne, yi_ne, m_nz, m_bit;

  assign op = op_e'(op_i);

  nib_opsel #(.W(W)) u_opsel (
    .op_i(op), .a_i(a_i), .m_i(m_i), .y_i(y_i), .imm_i(imm_i),
    .x_o(add_x), .z_o(add_z), .cin_o(add_cin)
  );

  nib_ripple #(.W(W)) u_add (
    .x_i(add_x), .y_i(add_z), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout)
  );

  nib_test #(.W(W), .BIT_W(BIT_W)) u_test (
    .a_i(a_i), .m_i(m_i), .y_i(y_i), .imm_i(imm_i), .bit_i(bit_i),
    .ya_ne_o(ya_ne), .yi_ne_o(yi_ne), .m_nz_o(m_nz), .m_bit_o(m_bit)
  );

  always_comb begin
    a_o    = a_i;
    y_o    = y_i;
    a_we_o = 1'b0;
    y_we_o = 1'b0;
    st_o   = 1'b1;
    case (op)
      OP_ADD_MA, OP_SUB_MA, OP_INC_M, OP_DEC_M, OP_DEC_A, OP_NEG_A: begin
        a_o = add_sum; a_we_o = 1'b1; st_o = add_cout;
      end
      OP_INC_A:               begin a_o = add_sum; a_we_o = 1'b1; end
      OP_INC_Y, OP_DEC_Y:     begin y_o = add_sum; y_we_o = 1'b1; st_o = add_cout; end
      OP_XOR_MA:              begin a_o = a_i ^ m_i; a_we_o = 1'b1; end
      OP_LE_AM, OP_LE_AI:     st_o = add_cout;
      OP_NZ_M:                st_o = m_nz;
      OP_NE_YA:               st_o = ya_ne;
      OP_NE_YI:               st_o = yi_ne;
      OP_TEST_BIT:            st_o = m_bit;
      OP_A_FROM_Y:            begin a_o = y_i;   a_we_o = 1'b1; end
      OP_Y_FROM_A:            begin y_o = a_i;   y_we_o = 1'b1; end
      OP_A_CLR:               begin a_o = '0;    a_we_o = 1'b1; end
      OP_A_FROM_M:            begin a_o = m_i;   a_we_o = 1'b1; end
      OP_Y_FROM_M:            begin y_o = m_i;   y_we_o = 1'b1; end
      OP_Y_FROM_I:            begin y_o = imm_i; y_we_o = 1'b1; end
      default:                ;
    endcase
  end
endmodule

// File: rtl/nib_alu_chk.sv
`timescale 1ns/1ps
module nib_alu_chk
  import nib_alu_pkg::*;
#(
  parameter int W     = 4,
  parameter int BIT_W = $clog2(W)
) (
  input logic [OP_W-1:0]  op_i,
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     m_i,
  input logic [W-1:0]     y_i,
  input logic [W-1:0]     imm_i,
  input logic [BIT_W-1:0] bit_i,
  input logic [W-1:0]     a_o,
  input logic [W-1:0]     y_o,
  input logic             a_we_o,
  input logic             y_we_o,
  input logic             st_o
);
  localparam int MAXV = (1 << W) - 1;

  always_comb begin
    if (op_i == OP_ADD_MA)
      a_r1_add: assert ({st_o, a_o} == ({1'b0, a_i} + {1'b0, m_i}) && a_we_o);
    if (op_i == OP_SUB_MA)
      a_r2_sub: assert (st_o == (a_i <= m_i) && a_o == W'(m_i - a_i) && a_we_o);
    if (op_i == OP_INC_M)
      a_r3_inc_m: assert (st_o == (int'(m_i) == MAXV) && a_o == W'(m_i + 1'b1));
    if (op_i == OP_DEC_M)
      a_r3_dec_m: assert (st_o == (m_i != '0) && a_o == W'(m_i - 1'b1));
    if (op_i == OP_INC_A)
      a_r4_inc_a: assert (st_o && a_o == W'(a_i + 1'b1));
    if (op_i == OP_DEC_A)
      a_r4_dec_a: assert (st_o == (a_i != '0) && a_o == W'(a_i - 1'b1));
    if (op_i == OP_INC_Y || op_i == OP_DEC_Y)
      a_r5_y_only: assert (y_we_o && !a_we_o);
    if (op_i == OP_NEG_A)
      a_r6_neg: assert (st_o == (a_i == '0) && W'(a_o + a_i) == '0);
    if (op_i == OP_XOR_MA)
      a_r7_xor: assert (st_o && (a_o ^ m_i) == a_i);
    if (op_i == OP_LE_AM)
      a_r8_le_am: assert (st_o == (a_i <= m_i) && !a_we_o && !y_we_o);
    if (op_i == OP_LE_AI)
      a_r8_le_ai: assert (st_o == (a_i <= imm_i) && !a_we_o && !y_we_o);
    if (op_i == OP_NE_YA)
      a_r9_ne_ya: assert (st_o == (y_i != a_i) && !a_we_o && !y_we_o);
    if (op_i == OP_TEST_BIT)
      a_r10_bit: assert (st_o == m_i[bit_i] && !a_we_o && !y_we_o);
    if (op_i == OP_NOP || int'(op_i) > 22)
      a_r11_idle: assert (st_o && !a_we_o && !y_we_o);
    if (!a_we_o)
      a_r12_a_hold: assert (a_o == a_i);
    if (!y_we_o)
      a_r12_y_hold: assert (y_o == y_i);
  end
endmodule

bind nib_alu nib_alu_chk #(.W(W), .BIT_W(BIT_W)) u_chk (.*);

// File: tb/sim_nib_alu.sv
`timescale 1ns/1ps
module sim_nib_alu;
  import nib_alu_pkg::*;

  typedef struct packed {
    op_e        op;
    logic [3:0] a, m, y, imm;
    logic [1:0] bidx;
    logic [3:0] ea, ey;
    logic       ewa, ewy, est;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{OP_ADD_MA,   4'h9, 4'h8, 4'h3, 4'h0, 2'd0, 4'h1, 4'h3, 1'b1, 1'b0, 1'b1}, // R1 carry
    '{OP_ADD_MA,   4'h7, 4'h8, 4'h3, 4'h0, 2'd0, 4'hF, 4'h3, 1'b1, 1'b0, 1'b0}, // R1 sum 15
    '{OP_SUB_MA,   4'h5, 4'h5, 4'h0, 4'h0, 2'd0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1}, // R2 equal
    '{OP_SUB_MA,   4'h6, 4'h5, 4'h0, 4'h0, 2'd0, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0}, // R2 borrow
    '{OP_INC_M,    4'h2, 4'hF, 4'h1, 4'h0, 2'd0, 4'h0, 4'h1, 1'b1, 1'b0, 1'b1}, // R3
    '{OP_INC_M,    4'h2, 4'hE, 4'h1, 4'h0, 2'd0, 4'hF, 4'h1, 1'b1, 1'b0, 1'b0}, // R3
    '{OP_DEC_M,    4'h2, 4'h0, 4'h1, 4'h0, 2'd0, 4'hF, 4'h1, 1'b1, 1'b0, 1'b0}, // R3
    '{OP_DEC_M,    4'h2, 4'h1, 4'h1, 4'h0, 2'd0, 4'h0, 4'h1, 1'b1, 1'b0, 1'b1}, // R3
    '{OP_INC_A,    4'hF, 4'h0, 4'h4, 4'h0, 2'd0, 4'h0, 4'h4, 1'b1, 1'b0, 1'b1}, // R4 wrap
    '{OP_INC_A,    4'h3, 4'h0, 4'h4, 4'h0, 2'd0, 4'h4, 4'h4, 1'b1, 1'b0, 1'b1}, // R4
    '{OP_DEC_A,    4'h0, 4'h0, 4'h4, 4'h0, 2'd0, 4'hF, 4'h4, 1'b1, 1'b0, 1'b0}, // R4
    '{OP_DEC_A,    4'h3, 4'h0, 4'h4, 4'h0, 2'd0, 4'h2, 4'h4, 1'b1, 1'b0, 1'b1}, // R4
    '{OP_INC_Y,    4'h6, 4'h0, 4'hF, 4'h0, 2'd0, 4'h6, 4'h0, 1'b0, 1'b1, 1'b1}, // R5
    '{OP_INC_Y,    4'h6, 4'h0, 4'h7, 4'h0, 2'd0, 4'h6, 4'h8, 1'b0, 1'b1, 1'b0}, // R5
    '{OP_DEC_Y,    4'h6, 4'h0, 4'h0, 4'h0, 2'd0, 4'h6, 4'hF, 1'b0, 1'b1, 1'b0}, // R5
    '{OP_DEC_Y,    4'h6, 4'h0, 4'h1, 4'h0, 2'd0, 4'h6, 4'h0, 1'b0, 1'b1, 1'b1}, // R5
    '{OP_NEG_A,    4'h0, 4'h5, 4'h2, 4'h0, 2'd0, 4'h0, 4'h2, 1'b1, 1'b0, 1'b1}, // R6
    '{OP_NEG_A,    4'h3, 4'h5, 4'h2, 4'h0, 2'd0, 4'hD, 4'h2, 1'b1, 1'b0, 1'b0}, // R6
    '{OP_XOR_MA,   4'hA, 4'h6, 4'h2, 4'h0, 2'd0, 4'hC, 4'h2, 1'b1, 1'b0, 1'b1}, // R7
    '{OP_LE_AM,    4'h4, 4'h4, 4'h2, 4'h0, 2'd0, 4'h4, 4'h2, 1'b0, 1'b0, 1'b1}, // R8
    '{OP_LE_AM,    4'h5, 4'h4, 4'h2, 4'h0, 2'd0, 4'h5, 4'h2, 1'b0, 1'b0, 1'b0}, // R8
    '{OP_LE_AI,    4'h2, 4'h9, 4'h2, 4'h1, 2'd0, 4'h2, 4'h2, 1'b0, 1'b0, 1'b0}, // R8
    '{OP_LE_AI,    4'h0, 4'h9, 4'h2, 4'h0, 2'd0, 4'h0, 4'h2, 1'b0, 1'b0, 1'b1}, // R8
    '{OP_NZ_M,     4'h1, 4'h0, 4'h2, 4'h0, 2'd0, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0}, // R9
    '{OP_NZ_M,     4'h1, 4'h8, 4'h2, 4'h0, 2'd0, 4'h1, 4'h2, 1'b0, 1'b0, 1'b1}, // R9
    '{OP_NE_YA,    4'h5, 4'h0, 4'h5, 4'h0, 2'd0, 4'h5, 4'h5, 1'b0, 1'b0, 1'b0}, // R9
    '{OP_NE_YA,    4'h6, 4'h0, 4'h5, 4'h0, 2'd0, 4'h6, 4'h5, 1'b0, 1'b0, 1'b1}, // R9
    '{OP_NE_YI,    4'h0, 4'h0, 4'h7, 4'h7, 2'd0, 4'h0, 4'h7, 1'b0, 1'b0, 1'b0}, // R9
    '{OP_TEST_BIT, 4'h0, 4'h4, 4'h0, 4'h0, 2'd2, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1}, // R10
    '{OP_TEST_BIT, 4'h0, 4'h4, 4'h0, 4'h0, 2'd1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0}, // R10
    '{OP_TEST_BIT, 4'h0, 4'h8, 4'h0, 4'h0, 2'd3, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1}, // R10
    '{OP_A_FROM_Y, 4'h1, 4'h2, 4'h6, 4'h9, 2'd0, 4'h6, 4'h6, 1'b1, 1'b0, 1'b1}, // R11
    '{OP_Y_FROM_I, 4'h1, 4'h2, 4'h6, 4'h9, 2'd0, 4'h1, 4'h9, 1'b0, 1'b1, 1'b1}, // R11
    '{OP_A_CLR,    4'h7, 4'h2, 4'h6, 4'h9, 2'd0, 4'h0, 4'h6, 1'b1, 1'b0, 1'b1}, // R11
    '{OP_Y_FROM_M, 4'h7, 4'hB, 4'h6, 4'h9, 2'd0, 4'h7, 4'hB, 1'b0, 1'b1, 1'b1}, // R11
    '{OP_NOP,      4'h7, 4'hB, 4'h6, 4'h9, 2'd0, 4'h7, 4'h6, 1'b0, 1'b0, 1'b1}  // R11 R12
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] op_i = '0;
  logic [3:0] a_i = '0, m_i = '0, y_i = '0, imm_i = '0;
  logic [1:0] bit_i = '0;
  logic [3:0] a_o, y_o;
  logic       a_we_o, y_we_o, st_o;
  int         checks = 0;
  int         failures = 0;

  always #4 clk = ~clk;

  nib_alu u0 (
    .op_i(op_i), .a_i(a_i), .m_i(m_i), .y_i(y_i), .imm_i(imm_i), .bit_i(bit_i),
    .a_o(a_o), .y_o(y_o), .a_we_o(a_we_o), .y_we_o(y_we_o), .st_o(st_o)
  );

  task automatic apply(input logic [4:0] op, input logic [3:0] a, m, y, imm,
                       input logic [1:0] b);
    @(posedge clk);
    op_i = op; a_i = a; m_i = m; y_i = y; imm_i = imm; bit_i = b;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] pack(logic [3:0] a, logic [3:0] y, logic wa, logic wy, logic st);
    return {a, y, wa, wy, st};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: idle select with zero operands (R11)
    @(negedge clk);
    check("R11 reset", pack(a_o, y_o, a_we_o, y_we_o, st_o), pack(4'h0, 4'h0, 1'b0, 1'b0, 1'b1));

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].m, VECS[i].y, VECS[i].imm, VECS[i].bidx);
      check($sformatf("R1-table vec%0d", i), pack(a_o, y_o, a_we_o, y_we_o, st_o),
            pack(VECS[i].ea, VECS[i].ey, VECS[i].ewa, VECS[i].ewy, VECS[i].est));
    end

    // R1 sweep
    for (int a = 0; a < 16; a++)
      for (int m = 0; m < 16; m++) begin
        apply(OP_ADD_MA, 4'(a), 4'(m), 4'h5, 4'h0, 2'd0);
        check("R1 add", pack(a_o, y_o, a_we_o, y_we_o, st_o),
              pack(4'((a + m) % 16), 4'h5, 1'b1, 1'b0, (a + m) > 15));
      end
    // R2 sweep
    for (int a = 0; a < 16; a++)
      for (int m = 0; m < 16; m++) begin
        apply(OP_SUB_MA, 4'(a), 4'(m), 4'h5, 4'h0, 2'd0);
        check("R2 sub", pack(a_o, y_o, a_we_o, y_we_o, st_o),
              pack(4'((m - a + 16) % 16), 4'h5, 1'b1, 1'b0, a <= m));
      end
    // R8 sweep
    for (int a = 0; a < 16; a++)
      for (int k = 0; k < 16; k++) begin
        apply(OP_LE_AI, 4'(a), 4'h3, 4'h5, 4'(k), 2'd0);
        check("R8 le imm", pack(a_o, y_o, a_we_o, y_we_o, st_o),
              pack(4'(a), 4'h5, 1'b0, 1'b0, a <= k));
      end
    // R11 unused code and remaining moves, R12 hold
    apply(5'd27, 4'hA, 4'h1, 4'h3, 4'h4, 2'd0);
    check("R11 unused", pack(a_o, y_o, a_we_o, y_we_o, st_o), pack(4'hA, 4'h3, 1'b0, 1'b0, 1'b1));
    apply(OP_Y_FROM_A, 4'hA, 4'h1, 4'h3, 4'h4, 2'd0);
    check("R11 y_from_a", pack(a_o, y_o, a_we_o, y_we_o, st_o), pack(4'hA, 4'hA, 1'b0, 1'b1, 1'b1));
    apply(OP_A_FROM_M, 4'hA, 4'h1, 4'h3, 4'h4, 2'd0);
    check("R11 a_from_m", pack(a_o, y_o, a_we_o, y_we_o, st_o), pack(4'h1, 4'h3, 1'b1, 1'b0, 1'b1));
    apply(OP_NE_YI, 4'hA, 4'h1, 4'h3, 4'h4, 2'd0);
    check("R9 R12 ne imm", pack(a_o, y_o, a_we_o, y_we_o, st_o), pack(4'hA, 4'h3, 1'b0, 1'b0, 1'b1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule